// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block produces the address used by one port of a synchronous RAM. In every clock cycle the access address comes from one of four places: the external address bus (load), the stored counter plus one (advance), the stored counter unchanged (hold), or a saved copy of the address taken at the most recent load (repeat). At the rising edge the working counter takes the address that was used, so a burst continues from wherever the last access landed.

Repeat costs no cycle. A read or write issued in the same cycle as the repeat strobe goes to the restored address. A separate register keeps the last-loaded address, and counting never changes it. The same start address can therefore be replayed any number of times.

A small register-array memory is attached so that bursts of reads and writes can be seen at the ports. Writes happen at the clock edge. Read data is registered and appears one cycle after its address.

Top module: `burst_addr_port`

## Requirements
- R1: An asynchronous active-low reset clears the working counter and the saved load address to zero, and clears the read data register. After reset, with all strobes high, `acc_addr` is 0, and a repeat also gives 0.
- R2: While `load_n` is 0 and `rpt_n` is 1, `acc_addr` equals `ext_addr` in that same cycle, and that address is used for the access. Different, non-sequential addresses may be loaded in back-to-back cycles.
- R3: While `load_n` and `rpt_n` are 1 and `step_n` is 0, `acc_addr` is the previous cycle's access address plus one, and the access in that cycle uses the incremented address.
- R4: While `load_n`, `rpt_n` and `step_n` are all 1, `acc_addr` equals the previous cycle's access address.
- R5: While `rpt_n` is 0, `acc_addr` equals the address captured at the most recent load, and a write in that same cycle goes to that address.
- R6: After a repeat, counting resumes from the restored address (saved+1, saved+2, …). Counting never changes the saved load address, so a later repeat returns to the same value.
- R7: Priority is repeat over load, load over advance, advance over hold. A load strobe during a repeat is ignored: neither `acc_addr` nor the saved address takes `ext_addr`.
- R8: Advancing from the all-ones address wraps to 0, modulo 2^AW.
- R9: When `wr_en` is 1, `wdata` is written at the rising edge to the word selected by the low MEM_AW bits of `acc_addr`.
- R10: After each rising edge, `rdata` holds the word stored at that edge's access address from before that edge's write, which gives a one-cycle pipelined read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | AW | External address bus |
| load_n | input | 1 | Active-low load strobe |
| step_n | input | 1 | Active-low count-enable |
| rpt_n | input | 1 | Active-low repeat strobe |
| wr_en | input | 1 | Write enable for the attached memory |
| wdata | input | DW | Write data |
| acc_addr | output | AW | Address used for this cycle's access |
| rdata | output | DW | Registered read data |

## Verification
The bench builds the block with AW=5, MEM_AW=5 and DW=8. With these values the memory covers the whole address space, so every counter value maps to its own word. Wrap-around from 31 to 0 is reached in a few cycles. Bursts, repeats and read-before-write behaviour can then be checked word by word against a model of 32 entries.

// File: rtl/burst_addr_port.sv
module burst_addr_port #(
  parameter int AW     = 17,
  parameter int MEM_AW = 4,
  parameter int DW     = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          load_n,
  input  logic          step_n,
  input  logic          rpt_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [AW-1:0] cnt_q;
  logic [AW-1:0] saved_q;
  logic [DW-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] widx;

  always_comb begin
    if (!rpt_n)       acc_addr = saved_q;
    else if (!load_n) acc_addr = ext_addr;
    else if (!step_n) acc_addr = cnt_q + 1'b1;
    else              acc_addr = cnt_q;
  end

  assign widx = acc_addr[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      saved_q <= '0;
    end else begin
      cnt_q <= acc_addr;
      if (rpt_n && !load_n) saved_q <= ext_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[widx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[widx];
  end

  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_n && load_n && !step_n && $past(rst_n)) |-> acc_addr == AW'($past(acc_addr) + 1'b1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_n && load_n && step_n && $past(rst_n)) |-> acc_addr == $past(acc_addr));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_n && !load_n) |=> saved_q == $past(ext_addr));

  // R6
  saved_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n || !rpt_n) |=> $stable(saved_q));

  // R5
  repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rpt_n && $past(rst_n) && $past(rpt_n) && !$past(load_n)) |-> acc_addr == $past(ext_addr));
endmodule

// File: tb/tb_burst_addr_port.sv
`timescale 1ns/1ps
module tb_burst_addr_port;
  localparam int AW = 5;
  localparam int MEM_AW = 5;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic load_n = 1'b1, step_n = 1'b1, rpt_n = 1'b1, wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] rdata;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  burst_addr_port #(.AW(AW), .MEM_AW(MEM_AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .load_n(load_n),
    .step_n(step_n), .rpt_n(rpt_n), .wr_en(wr_en), .wdata(wdata),
    .acc_addr(acc_addr), .rdata(rdata)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // drive one cycle, check the address before the edge, then pass the edge
  task automatic step(input logic ld, input logic cn, input logic rp,
                      input int ea, input logic w, input int wd,
                      input int exp_addr, input string tag);
    load_n = ld; step_n = cn; rpt_n = rp;
    ext_addr = AW'(ea); wr_en = w; wdata = DW'(wd);
    #1;
    check(tag, int'(acc_addr), exp_addr);
    @(posedge clk); #1;
    load_n = 1'b1; step_n = 1'b1; rpt_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic t_reset;
    #1; check("R1 idle after reset", int'(acc_addr), 0);
    check("R1 rdata after reset", int'(rdata), 0);
    step(1, 1, 0, 9, 0, 0, 0, "R1 repeat after reset");
  endtask

  task automatic t_load;
    step(0, 1, 1, 5, 0, 0, 5, "R2 load 5");
    step(0, 1, 1, 20, 0, 0, 20, "R2 load 20");
    step(0, 1, 1, 3, 0, 0, 3, "R2 load 3");
  endtask

  task automatic t_count;
    step(0, 1, 1, 10, 0, 0, 10, "R2 load 10");
    step(1, 0, 1, 0, 0, 0, 11, "R3 advance 11");
    step(1, 0, 1, 0, 0, 0, 12, "R3 advance 12");
    step(1, 0, 1, 0, 0, 0, 13, "R3 advance 13");
    step(1, 1, 1, 0, 0, 0, 13, "R4 hold 13");
    step(1, 1, 1, 27, 0, 0, 13, "R4 hold ignores bus");
  endtask

  task automatic t_repeat;
    step(0, 1, 1, 7, 0, 0, 7, "R2 load 7");
    step(1, 0, 1, 0, 0, 0, 8, "R3 advance 8");
    step(1, 0, 1, 0, 0, 0, 9, "R3 advance 9");
    step(1, 1, 0, 0, 1, 'hA5, 7, "R5 repeat with write");
    step(1, 0, 1, 0, 0, 0, 8, "R6 resume 8");
    step(1, 0, 1, 0, 0, 0, 9, "R6 resume 9");
    step(1, 1, 0, 0, 0, 0, 7, "R6 saved unchanged");
    check("R5 write landed at 7", int'(rdata), 'hA5);
  endtask

  task automatic t_priority;
    step(0, 1, 1, 4, 0, 0, 4, "R2 load 4");
    step(1, 0, 1, 0, 0, 0, 5, "R3 advance 5");
    step(0, 1, 0, 12, 0, 0, 4, "R7 repeat beats load");
    step(1, 1, 0, 0, 0, 0, 4, "R7 ignored load not saved");
    step(0, 0, 1, 9, 0, 0, 9, "R7 load beats advance");
    step(1, 0, 0, 0, 0, 0, 9, "R7 repeat beats advance");
  endtask

  task automatic t_wrap;
    step(0, 1, 1, 30, 0, 0, 30, "R2 load 30");
    step(1, 0, 1, 0, 0, 0, 31, "R8 advance 31");
    step(1, 0, 1, 0, 0, 0, 0, "R8 wrap 0");
    step(1, 0, 1, 0, 0, 0, 1, "R8 after wrap 1");
  endtask

  task automatic t_mem;
    step(0, 1, 1, 16, 1, 'h11, 16, "R9 write burst start");
    step(1, 0, 1, 0, 1, 'h22, 17, "R9 write burst 17");
    step(1, 0, 1, 0, 1, 'h33, 18, "R9 write burst 18");
    step(0, 1, 1, 16, 0, 0, 16, "R2 reload 16");
    check("R10 read 16", int'(rdata), 'h11);
    step(1, 0, 1, 0, 0, 0, 17, "R3 read addr 17");
    check("R10 read 17", int'(rdata), 'h22);
    step(1, 0, 1, 0, 0, 0, 18, "R3 read addr 18");
    check("R10 read 18", int'(rdata), 'h33);
    step(1, 1, 1, 0, 1, 'h44, 18, "R4 hold for overwrite");
    check("R10 read before write", int'(rdata), 'h33);
    step(1, 1, 1, 0, 0, 0, 18, "R4 hold readback");
    check("R9 overwrite stored", int'(rdata), 'h44);
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_load();
    t_count();
    t_repeat();
    t_priority();
    t_wrap();
    t_mem();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule